// File: doc/BRIEF.md
# Block-Level Flash Address Mapper

This block turns a logical page address into a physical flash location through a table kept per virtual block. The low bits of the logical address select a page inside a block (the remainder by the page count per block). The high bits select a virtual block (the quotient). Each virtual block may own two physical blocks. The first is a home block, where a page is written at its own offset. The second is an overflow block, filled strictly from its first page upward. Any physical block the mapper needs is taken from a free-block supplier, which is modelled by two plain input pins and one pulse output.

A write lands at the offset's page of the home block while that page is still unprogrammed. Once that page is used, the write goes to the next unwritten page of the overflow block, and that page records the offset it holds. A programmed page is never written again. The older copy simply becomes stale, and nothing marks it dead. A read therefore searches the overflow block for the highest page that carries the requested offset. If none does, the read falls back to the home page. A read of an address that was never written reports a miss.

Requests arrive on a valid/ready channel. `req_ready` is low only while reset is asserted or in the cycle just after reset is released. After that it stays high, so the channel exerts no back-pressure once it is up. Every accepted request gives exactly one `rsp_done` pulse in the following cycle. The result fields are valid only while `rsp_done` is high. The response side has no ready signal, so the consumer must take the pulse when it appears.

Top module: `fxl_block_mapper`

## Requirements
- R1: The logical page address is split into a virtual block (upper `$clog2(VBLKS)` bits, the quotient) and an offset (lower `$clog2(PAGES)` bits, the remainder). With 8 pages per block, address 1019 selects virtual block 127 and offset 3.
- R2: `req_ready` is high from the second cycle after reset release. Each accepted request gives exactly one `rsp_done` pulse, one cycle after acceptance, and `rsp_done` is never high otherwise.
- R3: A write to a virtual block that has no home block takes `free_blk` as its home block, pulses `free_take` in the acceptance cycle, and returns that block with page = offset and `rsp_hit`=1.
- R4: A write whose offset's home page is still unprogrammed returns the home block and page = offset, and does not pulse `free_take`.
- R5: A write whose home page is already programmed goes to the overflow block at pages 0, 1, 2, … in order. A programmed page is never returned for a second write.
- R6: When the first write of R5 finds no overflow block assigned, it takes `free_blk`, pulses `free_take`, and uses page 0 of that block.
- R7: A write that needs the overflow block while all its PAGES pages are used is refused with `rsp_full`=1, `rsp_hit`=0, block 0 and page 0, and it changes no mapping.
- R8: A write that needs a new block while `free_ok`=0 is refused as in R7, and `free_take` stays low.
- R9: A read of an offset whose home page was never programmed returns `rsp_hit`=0, `rsp_full`=0, block 0 and page 0.
- R10: A read returns the overflow block and the highest overflow page that holds the requested offset. If no overflow page holds it, the read returns the home block and page = offset, with `rsp_hit`=1.
- R11: After reset `rsp_done` is low and every virtual block is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lpa | input | 10 | Logical page address |
| free_ok | input | 1 | Supplier has a free block on free_blk |
| free_blk | input | 8 | Free physical block number offered |
| free_take | output | 1 | Pulse: the offered free block is consumed at this edge |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_hit | output | 1 | Read found data / write placed |
| rsp_full | output | 1 | Write refused (no page or no free block) |
| rsp_blk | output | 8 | Physical block of the result |
| rsp_page | output | 3 | Physical page of the result |

## Verification
Writes are driven in several patterns, and each pattern separates a different behaviour. First writes to an unmapped virtual block show that a block is taken from the supplier. Repeated writes to a single offset show that consecutive overflow pages are used. Interleaved offsets show that each overflow page keeps its own offset tag. Reads after each of these show the newest copy against the fallback to the home page, and a read of an unwritten sibling offset must still miss. Filling the overflow block and then withholding the free supply exercise both kinds of refusal, and the reads that follow show that a refused write left the mapping unchanged.

// File: rtl/fxl_pkg.sv
package fxl_pkg;
  typedef enum logic [1:0] {
    PL_NONE = 2'd0,
    PL_HOME = 2'd1,
    PL_OVF  = 2'd2
  } place_e;
endpackage

// File: rtl/fxl_map_table.sv
module fxl_map_table #(
  parameter int VBLKS  = 128,
  parameter int PBLK_W = 8,
  localparam int VB_W  = $clog2(VBLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VB_W-1:0]   vb,
  output logic              home_vld,
  output logic [PBLK_W-1:0] home_blk,
  output logic              ovf_vld,
  output logic [PBLK_W-1:0] ovf_blk,
  input  logic              set_home,
  input  logic              set_ovf,
  input  logic [PBLK_W-1:0] new_blk
);
  logic              home_vld_q [VBLKS];
  logic [PBLK_W-1:0] home_blk_q [VBLKS];
  logic              ovf_vld_q  [VBLKS];
  logic [PBLK_W-1:0] ovf_blk_q  [VBLKS];

  assign home_vld = home_vld_q[vb];
  assign home_blk = home_blk_q[vb];
  assign ovf_vld  = ovf_vld_q[vb];
  assign ovf_blk  = ovf_blk_q[vb];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < VBLKS; i++) begin
        home_vld_q[i] <= 1'b0;
        home_blk_q[i] <= '0;
        ovf_vld_q[i]  <= 1'b0;
        ovf_blk_q[i]  <= '0;
      end
    end else begin
      if (set_home) begin
        home_vld_q[vb] <= 1'b1;
        home_blk_q[vb] <= new_blk;
      end
      if (set_ovf) begin
        ovf_vld_q[vb] <= 1'b1;
        ovf_blk_q[vb] <= new_blk;
      end
    end
  end

  AST_HOME_ASSIGNED_ONCE: assert property (@(posedge clk) disable iff (rst)
    set_home |-> !home_vld_q[vb]); // R3
  AST_OVF_ASSIGNED_ONCE: assert property (@(posedge clk) disable iff (rst)
    set_ovf |-> (home_vld_q[vb] && !ovf_vld_q[vb])); // R6
endmodule

// File: rtl/fxl_page_state.sv
module fxl_page_state #(
  parameter int VBLKS = 128,
  parameter int PAGES = 8,
  localparam int VB_W  = $clog2(VBLKS),
  localparam int OFF_W = $clog2(PAGES),
  localparam int CNT_W = $clog2(PAGES + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [VB_W-1:0]          vb,
  input  logic [OFF_W-1:0]         off,
  output logic                     home_used,
  output logic [CNT_W-1:0]         ovf_cnt,
  output logic [PAGES*OFF_W-1:0]   ovf_tags,
  input  logic                     mark_home,
  input  logic                     push_ovf
);
  logic [PAGES-1:0]       used_q [VBLKS];
  logic [CNT_W-1:0]       cnt_q  [VBLKS];
  logic [PAGES*OFF_W-1:0] tag_q  [VBLKS];

  assign home_used = used_q[vb][off];
  assign ovf_cnt   = cnt_q[vb];
  assign ovf_tags  = tag_q[vb];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < VBLKS; i++) begin
        used_q[i] <= '0;
        cnt_q[i]  <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      if (mark_home) used_q[vb][off] <= 1'b1;
      if (push_ovf) begin
        tag_q[vb][cnt_q[vb][OFF_W-1:0]*OFF_W +: OFF_W] <= off;
        cnt_q[vb] <= cnt_q[vb] + 1'b1;
      end
    end
  end

  AST_NO_HOME_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    mark_home |-> !used_q[vb][off]); // R5
  AST_NO_OVF_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push_ovf |-> (cnt_q[vb] < CNT_W'(PAGES))); // R7
  AST_OVF_NEEDS_USED_HOME: assert property (@(posedge clk) disable iff (rst)
    push_ovf |-> used_q[vb][off]); // R5
endmodule

// File: rtl/fxl_ovf_scan.sv
module fxl_ovf_scan #(
  parameter int PAGES = 8,
  localparam int OFF_W = $clog2(PAGES),
  localparam int CNT_W = $clog2(PAGES + 1)
) (
  input  logic [CNT_W-1:0]       cnt,
  input  logic [PAGES*OFF_W-1:0] tags,
  input  logic [OFF_W-1:0]       off,
  output logic                   found,
  output logic [OFF_W-1:0]       idx
);
  logic [PAGES-1:0] match;

  for (genvar g = 0; g < PAGES; g++) begin : g_cmp
    assign match[g] = (CNT_W'(g) < cnt) && (tags[g*OFF_W +: OFF_W] == off);
  end

  // highest matching page is the newest copy
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < PAGES; i++) begin
      if (match[i]) begin
        found = 1'b1;
        idx   = OFF_W'(i);
      end
    end
  end
endmodule

// File: rtl/fxl_block_mapper.sv
module fxl_block_mapper #(
  parameter int VBLKS  = 128,
  parameter int PAGES  = 8,
  parameter int PBLK_W = 8,
  localparam int VB_W  = $clog2(VBLKS),
  localparam int OFF_W = $clog2(PAGES),
  localparam int CNT_W = $clog2(PAGES + 1),
  localparam int LPA_W = VB_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [LPA_W-1:0]  req_lpa,
  input  logic              free_ok,
  input  logic [PBLK_W-1:0] free_blk,
  output logic              free_take,
  output logic              rsp_done,
  output logic              rsp_hit,
  output logic              rsp_full,
  output logic [PBLK_W-1:0] rsp_blk,
  output logic [OFF_W-1:0]  rsp_page
);
  import fxl_pkg::*;

  logic              ready_q;
  logic              acc;
  logic [VB_W-1:0]   vb;
  logic [OFF_W-1:0]  off;
  logic              home_vld, ovf_vld, home_used, found;
  logic [PBLK_W-1:0] home_blk, ovf_blk;
  logic [CNT_W-1:0]  ovf_cnt;
  logic [PAGES*OFF_W-1:0] ovf_tags;
  logic [OFF_W-1:0]  hit_idx;
  place_e            place;
  logic              take, refuse, hit;
  logic [PBLK_W-1:0] out_blk;
  logic [OFF_W-1:0]  out_page;

  assign req_ready = ready_q;
  assign acc = req_valid && ready_q;
  assign vb  = req_lpa[LPA_W-1:OFF_W];
  assign off = req_lpa[OFF_W-1:0];

  fxl_map_table #(.VBLKS(VBLKS), .PBLK_W(PBLK_W)) u_table (
    .clk(clk), .rst(rst), .vb(vb),
    .home_vld(home_vld), .home_blk(home_blk),
    .ovf_vld(ovf_vld), .ovf_blk(ovf_blk),
    .set_home(acc && place == PL_HOME && take),
    .set_ovf(acc && place == PL_OVF && take),
    .new_blk(free_blk)
  );

  fxl_page_state #(.VBLKS(VBLKS), .PAGES(PAGES)) u_pages (
    .clk(clk), .rst(rst), .vb(vb), .off(off),
    .home_used(home_used), .ovf_cnt(ovf_cnt), .ovf_tags(ovf_tags),
    .mark_home(acc && place == PL_HOME),
    .push_ovf(acc && place == PL_OVF)
  );

  fxl_ovf_scan #(.PAGES(PAGES)) u_scan (
    .cnt(ovf_cnt), .tags(ovf_tags), .off(off),
    .found(found), .idx(hit_idx)
  );

  // placement / lookup decision
  always_comb begin
    place    = PL_NONE;
    take     = 1'b0;
    refuse   = 1'b0;
    hit      = 1'b0;
    out_blk  = '0;
    out_page = '0;
    if (req_write) begin
      if (!home_vld) begin
        if (free_ok) begin
          place = PL_HOME; take = 1'b1; out_blk = free_blk; out_page = off;
        end else refuse = 1'b1;
      end else if (!home_used) begin
        place = PL_HOME; out_blk = home_blk; out_page = off;
      end else if (!ovf_vld) begin
        if (free_ok) begin
          place = PL_OVF; take = 1'b1; out_blk = free_blk; out_page = '0;
        end else refuse = 1'b1;
      end else if (ovf_cnt < CNT_W'(PAGES)) begin
        place = PL_OVF; out_blk = ovf_blk; out_page = ovf_cnt[OFF_W-1:0];
      end else refuse = 1'b1;
      hit = !refuse;
    end else if (home_vld && home_used) begin
      hit = 1'b1;
      if (found) begin
        out_blk = ovf_blk; out_page = hit_idx;
      end else begin
        out_blk = home_blk; out_page = off;
      end
    end
  end

  assign free_take = acc && take;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q  <= 1'b0;
      rsp_done <= 1'b0;
      rsp_hit  <= 1'b0;
      rsp_full <= 1'b0;
      rsp_blk  <= '0;
      rsp_page <= '0;
    end else begin
      ready_q  <= 1'b1;
      rsp_done <= acc;
      rsp_hit  <= acc && hit;
      rsp_full <= acc && refuse;
      rsp_blk  <= acc ? out_blk : '0;
      rsp_page <= acc ? out_page : '0;
    end
  end

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_done); // R2
  AST_REFUSE_NOT_HIT: assert property (@(posedge clk) disable iff (rst)
    rsp_full |-> (rsp_done && !rsp_hit && rsp_blk == '0)); // R7
  AST_TAKE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    free_take |-> (free_ok && req_write)); // R8
  AST_READ_NEVER_FULL: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write) |=> !rsp_full); // R9
endmodule

// File: tb/fxl_block_mapper_test.sv
module fxl_block_mapper_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [9:0] req_lpa = '0;
  logic       free_ok = 1'b0;
  logic [7:0] free_blk = '0;
  logic       free_take;
  logic       rsp_done, rsp_hit, rsp_full;
  logic [7:0] rsp_blk;
  logic [2:0] rsp_page;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic       hit;
    logic       full;
    logic [7:0] blk;
    logic [2:0] page;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  fxl_block_mapper uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_lpa(req_lpa), .free_ok(free_ok),
    .free_blk(free_blk), .free_take(free_take), .rsp_done(rsp_done),
    .rsp_hit(rsp_hit), .rsp_full(rsp_full), .rsp_blk(rsp_blk),
    .rsp_page(rsp_page)
  );

  task automatic check(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  // driver: one request per call, starting at a falling edge
  task automatic req(input bit wr, input int lpa, input bit fok, input int fblk,
                     input bit take, input bit hit, input bit full,
                     input int blk, input int page, input string tag);
    exp_t e;
    req_valid = 1'b1;
    req_write = wr;
    req_lpa   = 10'(lpa);
    free_ok   = fok;
    free_blk  = 8'(fblk);
    e.hit = hit; e.full = full; e.blk = 8'(blk); e.page = 3'(page);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    check(free_take == take, {tag, " free_take"}, $sformatf("%0b", free_take),
          $sformatf("%0b", take));
    @(negedge clk);
  endtask

  task automatic idle();
    req_valid = 1'b0;
    free_ok   = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops one expected item per done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected done", "done=1", "done=0");
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_hit, rsp_full, rsp_blk, rsp_page} == e, t,
                $sformatf("hit=%0b full=%0b blk=%0d page=%0d", rsp_hit, rsp_full, rsp_blk, rsp_page),
                $sformatf("hit=%0b full=%0b blk=%0d page=%0d", e.hit, e.full, e.blk, e.page));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(rsp_done == 1'b0, "R11 done low in reset", $sformatf("%0b", rsp_done), "0");
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R2 ready after reset", $sformatf("%0b", req_ready), "1");

    // R11 / R9: unmapped after reset
    req(0, 1019, 1, 77, 0, 0, 0, 0, 0, "R11 R9 read unmapped 1019");
    // R1 R3: 1019 -> vblock 127 offset 3, home block taken from supply
    req(1, 1019, 1, 9, 1, 1, 0, 9, 3, "R1 R3 first write 1019");
    // R4: free home page, no take
    req(1, 1016, 1, 50, 0, 1, 0, 9, 0, "R4 write 1016 home page");
    req(0, 1019, 0, 0, 0, 1, 0, 9, 3, "R10 read home fallback 1019");
    // R5 R6: overflow block from supply
    req(1, 1019, 1, 23, 1, 1, 0, 23, 0, "R5 R6 overflow first 1019");
    req(1, 1016, 1, 60, 0, 1, 0, 23, 1, "R5 overflow page1 1016");
    req(1, 1019, 0, 0, 0, 1, 0, 23, 2, "R5 overflow page2 1019");
    req(0, 1019, 0, 0, 0, 1, 0, 23, 2, "R10 newest 1019");
    req(0, 1016, 0, 0, 0, 1, 0, 23, 1, "R10 newest 1016");
    req(0, 1017, 0, 0, 0, 0, 0, 0, 0, "R9 read unwritten sibling 1017");
    req(1, 1017, 0, 0, 0, 1, 0, 9, 1, "R4 write 1017 home page");
    req(0, 1017, 0, 0, 0, 1, 0, 9, 1, "R10 read 1017 home");
    // fill overflow pages 3..7
    for (int p = 3; p < 8; p++)
      req(1, 1016, 0, 0, 0, 1, 0, 23, p, $sformatf("R5 overflow fill page%0d", p));
    // R7: full overflow block
    req(1, 1019, 1, 88, 0, 0, 1, 0, 0, "R7 overflow full refused");
    req(0, 1019, 0, 0, 0, 1, 0, 23, 2, "R7 mapping unchanged 1019");
    req(0, 1016, 0, 0, 0, 1, 0, 23, 7, "R10 newest 1016 page7");
    idle();
    // R8: no free block available
    req(1, 5, 0, 40, 0, 0, 1, 0, 0, "R8 no supply for home");
    req(0, 5, 0, 0, 0, 0, 0, 0, 0, "R8 refused write left unmapped");
    req(1, 5, 1, 40, 1, 1, 0, 40, 5, "R3 home after supply");
    req(1, 5, 0, 41, 0, 0, 1, 0, 0, "R8 no supply for overflow");
    req(0, 5, 0, 0, 0, 1, 0, 40, 5, "R8 read after refused overflow");
    req(1, 13, 1, 41, 1, 1, 0, 41, 5, "R1 vblock1 separate table entry");
    idle();
    check(exp_q.size() == 0, "R2 all responses seen",
          $sformatf("%0d", exp_q.size()), "0");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule